// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the small register file that sits in front of an inter-VM shared-memory device. Software talks to it over a simple 32-bit word bus, one access per cycle. The block holds an interrupt enable mask, an interrupt cause word, a read-only identifier for this peer, and a write-only doorbell. A write to the doorbell becomes a one-cycle outbound notify request that names a destination peer and a vector. A notify pulse from the peer transport sets the cause word. A level interrupt is raised while any cause bit is also enabled.

Reading the cause word returns it and clears it in the same access, so software acknowledges an event by reading it. Software may also load the cause word directly, which lets a driver raise an interrupt on itself for testing. The 256-byte window decodes only its first four words. Every other offset reads as zero and ignores writes.

Top module: `shm_doorbell_regs`

## Requirements
- R1: After reset, the enable mask and the cause word are 0, irq is low, no notify is issued and no read response is valid.
- R2: Byte offset 0x0 holds the enable mask. Every one of its 32 bits can be written and read back, so 0xFFFFFFFF reads back unchanged.
- R3: A write to byte offset 0x4 loads the cause word with the write data. A read of offset 0x4 returns the current cause word and leaves it 0, so a second read returns 0.
- R4: A pulse on in_notify ORs bit 0 into the cause word. When it falls in the same cycle as a clearing read, the read returns the old value and the cause word holds 1 afterwards.
- R5: Byte offset 0x8 reads as self_id in bits 15:0 with zeros above. Writes to it change nothing.
- R6: A read of byte offset 0xC returns 0. A write to it makes out_valid high for exactly the following cycle, with out_peer equal to write data bits 31:16 and out_vector equal to bits 15:0.
- R7: out_valid is high only in the cycle after a doorbell write.
- R8: irq is high exactly when the cause word and the enable mask share a set bit. It is low in the cycle after a clearing read that had no in_notify.
- R9: Byte offsets 0x10 to 0xFC read as 0. Writes there change neither the mask nor the cause word, and they issue no notify. Address bits 1:0 are ignored.
- R10: rsp_valid is high in the cycle after each read request, and only then. rsp_rdata carries the value the register held when the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address within the 256-byte window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| self_id | input | 16 | This peer's identifier |
| in_notify | input | 1 | Inbound notify pulse from the transport |
| out_valid | output | 1 | Outbound notify request pulse |
| out_peer | output | 16 | Destination peer of the notify |
| out_vector | output | 16 | Vector number of the notify |
| irq | output | 1 | Level interrupt |

## Verification
If the cause word is corrupted, irq shows it in the cycle after the state goes wrong, because irq is a direct reduction of the registers. It also shows one cycle after the next read of offset 0x4. A wrong clear or set priority appears as a nonzero or zero second read. A mis-decoded offset either leaks a nonzero value on an unused word, or disturbs the mask or cause word, which is seen on the next readback. Doorbell packing errors are visible on out_peer and out_vector in the cycle after the write.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DATA_W = 32;
    localparam int ID_W   = 16;
    localparam int VEC_W  = DATA_W - ID_W;

    // word indices (byte offset / 4); order is decoded by software
    localparam int WIDX_MASK = 0;
    localparam int WIDX_CAUSE = 1;
    localparam int WIDX_SELF = 2;
    localparam int WIDX_BELL = 3;

    typedef enum logic [2:0] {
        SEL_MASK,
        SEL_CAUSE,
        SEL_SELF,
        SEL_BELL,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              vld;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [ID_W-1:0]  peer;
        logic [VEC_W-1:0] vector;
    } notify_t;

    function automatic notify_t unpack_bell(input logic [DATA_W-1:0] w);
        notify_t n;
        n.peer   = w[DATA_W-1:VEC_W];
        n.vector = w[VEC_W-1:0];
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] read_word(
        input reg_sel_e          sel,
        input logic [DATA_W-1:0] mask,
        input logic [DATA_W-1:0] cause,
        input logic [ID_W-1:0]   id
    );
        logic [DATA_W-1:0] r;
        unique case (sel)
            SEL_MASK:  r = mask;
            SEL_CAUSE: r = cause;
            SEL_SELF:  r = {{(DATA_W-ID_W){1'b0}}, id};
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output bus_req_t          bus
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic [1:0]        unused_byte_lane;

    assign widx             = req_addr[ADDR_W-1:2];
    assign unused_byte_lane = req_addr[1:0];

    always_comb begin
        bus.vld   = req_valid;
        bus.wr    = req_write;
        bus.wdata = req_wdata;
        if (widx == WIDX_W'(WIDX_MASK))
            bus.sel = SEL_MASK;
        else if (widx == WIDX_W'(WIDX_CAUSE))
            bus.sel = SEL_CAUSE;
        else if (widx == WIDX_W'(WIDX_SELF))
            bus.sel = SEL_SELF;
        else if (widx == WIDX_W'(WIDX_BELL))
            bus.sel = SEL_BELL;
        else
            bus.sel = SEL_NONE;
    end

endmodule

// File: rtl/dbell_cause_reg.sv
module dbell_cause_reg
    import dbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_load,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              sw_clear,
    input  logic              hw_set,
    output logic [DATA_W-1:0] cause_q
);
    logic [DATA_W-1:0] cause_d;

    // clear, then software load, then hardware set: the set always survives
    always_comb begin
        cause_d = cause_q;
        if (sw_clear) cause_d = '0;
        if (sw_load)  cause_d = sw_data;
        if (hw_set)   cause_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= cause_d;
    end

endmodule

// File: rtl/dbell_readback.sv
module dbell_readback
    import dbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          bus,
    input  logic [DATA_W-1:0] mask_q,
    input  logic [DATA_W-1:0] cause_q,
    input  logic [ID_W-1:0]   self_id,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic rd_go;
    assign rd_go = bus.vld && !bus.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            rsp_rdata <= rd_go ? read_word(bus.sel, mask_q, cause_q, self_id) : '0;
        end
    end

endmodule

// File: rtl/dbell_notify_out.sv
module dbell_notify_out
    import dbell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t bus,
    output logic     out_valid,
    output notify_t  out_req
);
    logic ring;
    assign ring = bus.vld && bus.wr && (bus.sel == SEL_BELL);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_req   <= '0;
        end else begin
            out_valid <= ring;
            if (ring) out_req <= unpack_bell(bus.wdata);
        end
    end

endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
    import dbell_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [ID_W-1:0]   self_id,
    input  logic              in_notify,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_peer,
    output logic [VEC_W-1:0]  out_vector,
    output logic              irq
);
    bus_req_t          bus;
    notify_t           nreq;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] status_q;
    logic              cause_wr;
    logic              cause_rd;

    dbell_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus       (bus)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (bus.vld && bus.wr && bus.sel == SEL_MASK)
            mask_q <= bus.wdata;
    end

    assign cause_wr = bus.vld &&  bus.wr && (bus.sel == SEL_CAUSE);
    assign cause_rd = bus.vld && !bus.wr && (bus.sel == SEL_CAUSE);

    dbell_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .sw_load  (cause_wr),
        .sw_data  (bus.wdata),
        .sw_clear (cause_rd),
        .hw_set   (in_notify),
        .cause_q  (status_q)
    );

    dbell_readback u_rb (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .mask_q    (mask_q),
        .cause_q   (status_q),
        .self_id   (self_id),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    dbell_notify_out u_ntf (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .out_valid (out_valid),
        .out_req   (nreq)
    );

    assign out_peer   = nreq.peer;
    assign out_vector = nreq.vector;
    assign irq        = |(status_q & mask_q);

endmodule

// File: rtl/dbell_checker.sv
module dbell_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [15:0]       self_id,
    input logic              in_notify,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              out_valid,
    input logic              irq,
    input logic [31:0]       status_q
);
    logic [ADDR_W-3:0] w;
    logic rd, wr_bell, rd_cause, rd_self, rd_hole;
    assign w        = req_addr[ADDR_W-1:2];
    assign rd       = req_valid && !req_write;
    assign wr_bell  = req_valid && req_write && (w == 3);
    assign rd_cause = rd && (w == 1);
    assign rd_self  = rd && (w == 2);
    assign rd_hole  = rd && (w > 3);

    a_r7_notify_only_after_bell: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(wr_bell));
    a_r6_bell_gives_notify: assert property (@(posedge clk) disable iff (rst)
        wr_bell |=> out_valid);
    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        rd |=> rsp_valid);
    a_r10_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd));
    a_r4_notify_sets_bit0: assert property (@(posedge clk) disable iff (rst)
        in_notify |=> status_q[0]);
    a_r8_irq_drops_after_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_cause && !in_notify) |=> !irq);
    a_r5_self_readback: assert property (@(posedge clk) disable iff (rst)
        rd_self |=> rsp_rdata == {16'h0, $past(self_id)});
    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        rd_hole |=> rsp_rdata == 32'h0);

endmodule

bind shm_doorbell_regs dbell_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .self_id   (self_id),
    .in_notify (in_notify),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .out_valid (out_valid),
    .irq       (irq),
    .status_q  (status_q)
);

// File: tb/sim_shm_doorbell_regs.sv
module sim_shm_doorbell_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [15:0] self_id = '0;
    logic        in_notify = 1'b0;
    logic        rsp_valid, out_valid, irq;
    logic [31:0] rsp_rdata;
    logic [15:0] out_peer, out_vector;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shm_doorbell_regs u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .self_id(self_id), .in_notify(in_notify),
        .out_valid(out_valid), .out_peer(out_peer), .out_vector(out_vector),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // captured at the negedge after a write
    logic        cap_valid;
    logic [15:0] cap_peer, cap_vec;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        cap_valid = out_valid; cap_peer = out_peer; cap_vec = out_vector;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic notify);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; in_notify = notify;
        @(negedge clk);
        req_valid = 1'b0; in_notify = 1'b0;
        check("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 out_valid", {31'b0, out_valid}, 0);
        check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
        rd(8'h00, v, 0); check("R1 mask", v, 0);
        rd(8'h04, v, 0); check("R1 cause", v, 0);
        rd(8'h08, v, 0); check("R5 self at reset", v, 0);
        @(negedge clk);
        check("R10 rsp_valid idle", {31'b0, rsp_valid}, 0);

        // R2 mask sweep
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v, 0); check("R2 all ones", v, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            wr(8'h00, 32'h1 << i); rd(8'h00, v, 0); check("R2 walk", v, 32'h1 << i);
        end
        for (int i = 0; i < 16; i++) begin
            wr(8'h00, 32'h9E37_79B9 * (i + 1)); rd(8'h00, v, 0);
            check("R2 pattern", v, 32'h9E37_79B9 * (i + 1));
        end

        // R3 cause load / read-to-clear; R8 irq
        wr(8'h00, 32'h0);
        for (int i = 0; i < 12; i++) begin
            wr(8'h04, 32'h0F0F_1357 ^ (32'h1 << i));
            check("R8 irq masked off", {31'b0, irq}, 0);
            rd(8'h04, v, 0); check("R3 first read", v, 32'h0F0F_1357 ^ (32'h1 << i));
            rd(8'h04, v, 0); check("R3 second read", v, 0);
        end
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 8; s++) begin
                wr(8'h00, 32'h1 << (m * 4));
                wr(8'h04, 32'h1 << (s * 4));
                check("R8 irq overlap", {31'b0, irq}, {31'b0, m == s});
                rd(8'h04, v, 0);
                check("R8 irq after clear", {31'b0, irq}, 0);
            end
        end

        // R4 inbound notify, and collision with a clearing read
        wr(8'h00, 32'h1);
        @(negedge clk); in_notify = 1'b1; @(negedge clk); in_notify = 1'b0;
        check("R4 irq from notify", {31'b0, irq}, 1);
        rd(8'h04, v, 0); check("R4 notify sets bit0", v, 1);
        wr(8'h04, 32'h0000_0080);
        rd(8'h04, v, 1); check("R4 collide old value", v, 32'h80);
        check("R4 irq still set", {31'b0, irq}, 1);
        rd(8'h04, v, 0); check("R4 set wins", v, 1);
        @(negedge clk); req_valid = 1; req_write = 1; req_addr = 8'h04;
        req_wdata = 32'hA000_0000; in_notify = 1;
        @(negedge clk); req_valid = 0; req_write = 0; in_notify = 0;
        rd(8'h04, v, 0); check("R4 notify with load", v, 32'hA000_0001);

        // R5 self id
        for (int i = 0; i < 8; i++) begin
            self_id = 16'h1357 * (i + 3);
            wr(8'h08, 32'hFFFF_FFFF);
            rd(8'h08, v, 0); check("R5 self id", v, {16'h0, 16'h1357 * (i + 3)});
        end

        // R6 doorbell
        for (int i = 0; i < 16; i++) begin
            wr(8'h0C, {16'h0101 * i, 16'hF000 >> i});
            check("R6 valid", {31'b0, cap_valid}, 1);
            check("R6 peer", {16'h0, cap_peer}, {16'h0, 16'h0101 * i});
            check("R6 vector", {16'h0, cap_vec}, {16'h0, 16'hF000 >> i});
            @(negedge clk);
            check("R6 single pulse", {31'b0, out_valid}, 0);
        end
        rd(8'h0C, v, 0); check("R6 bell reads zero", v, 0);

        // R7 no notify from other writes
        wr(8'h00, 32'h5); check("R7 no notify mask", {31'b0, cap_valid}, 0);
        wr(8'h04, 32'h0); check("R7 no notify cause", {31'b0, cap_valid}, 0);

        // R9 holes, and ignored low address bits
        wr(8'h00, 32'hCAFE_0001); wr(8'h04, 32'h0000_0100);
        for (int a = 16; a < 256; a += 4) begin
            wr(a[7:0], 32'hFFFF_FFFF);
            check("R9 hole no notify", {31'b0, cap_valid}, 0);
            rd(a[7:0], v, 0); check("R9 hole reads zero", v, 0);
        end
        rd(8'h03, v, 0); check("R9 mask intact", v, 32'hCAFE_0001);
        rd(8'h06, v, 0); check("R9 cause intact", v, 32'h0000_0100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule